// File: doc/BRIEF.md
# Two-Level Eight-Source Interrupt Controller

This block gathers the interrupt requests of an 8-bit microcontroller and picks the one the CPU takes next. There are eight sources: four active-low external pins, three timer request lines and one serial request line. The two standard external pins take their trigger mode, enable and priority from inputs. The third and fourth pins are set up through a small control register that software can write as a byte or one bit at a time. The pins pass through a synchronizer. In edge mode a falling edge sets a flag. In level mode the request follows the pin. The winning request is chosen first by priority level (high beats low) and then by a fixed polling order.

The block raises `irq` and presents an 8-bit vector address while a request is eligible. When the CPU pulses `ack`, the block records which level is now in service and clears the edge flag of the source it took. While a low-level handler runs, only high-level requests can interrupt it. While a high-level handler runs, nothing can. A `reti` pulse ends the innermost active level.

Top module: `intc_two_level`

## Requirements
- R1: After reset the control register reads 00h, `irq` is low and neither service level is active.
- R2: The control register accepts a byte write and a single-bit write (bit write applied after byte write), and reads back what was stored. Pin 2 uses bits 3:0 as {priority, enable, flag, trigger type}. Pin 3 uses bits 7:4 in the same order. Trigger type 1 selects falling edge and 0 selects low level.
- R3: In edge mode, a falling edge on a pin sets that pin's flag by the third rising clock edge after the pin goes low. The flag raises the request while the source is enabled.
- R4: In level mode, the request follows the synchronized pin being low. No flag is latched, and a stored flag bit does not make a request.
- R5: The vector is 03h + 8 × index, with the indices ext0=0, timer0=1, ext1=2, timer1=3, serial=4, timer2=5, ext2=6, ext3=7.
- R6: Among requests of one priority level, the lowest index wins.
- R7: An eligible high-priority request beats every low-priority request, whatever its index.
- R8: An `ack` while `irq` is high enters the winner's level. It also clears the winner's flag if that source is in edge mode. A level-mode request stays asserted.
- R9: While the low level is in service, only high-priority requests raise `irq`. While the high level is in service, `irq` stays low.
- R10: `reti` ends the high level if it is active, and otherwise ends the low level.
- R11: A disabled source never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 4 | External interrupt pins, active low, index = pin number |
| edge_sel01 | input | 2 | Trigger mode for pins 0 and 1 (1 = falling edge) |
| std_en | input | 6 | Enables for source indices 0 to 5 |
| std_hi | input | 6 | High-priority select for source indices 0 to 5 |
| tmr_req | input | 3 | Timer 0, 1, 2 request lines |
| ser_req | input | 1 | Serial request line |
| reg_wr | input | 1 | Byte write strobe for the control register |
| reg_wdata | input | 8 | Byte write data |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_sel | input | 3 | Bit position for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| reg_rdata | output | 8 | Control register contents |
| ack | input | 1 | CPU accepts the presented vector |
| reti | input | 1 | CPU returns from the current handler |
| irq | output | 1 | Interrupt request to the CPU |
| vec | output | 8 | Vector address of the winning source |
| svc_hi | output | 1 | High level in service |
| svc_lo | output | 1 | Low level in service |

## Verification
Arbitration is swept over all 256 combinations of the eight request lines, each under four priority patterns (none high, all high, and two mixed). The all-low and all-high patterns separate polling order from level selection. The mixed patterns show whether a high source with a poor polling position still beats a low source with a good one. Separate sequences hold a pin low through ack and reti in each trigger mode: a flag that is cleared once and not set again marks edge behaviour, and a request that comes back marks level behaviour. A nested sequence of low service, high preemption and two returns exercises the service-level bookkeeping.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC = 8;
    localparam int IDXW = $clog2(NSRC);

    typedef enum logic [IDXW-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5,
        SRC_EXT2 = 3'd6,
        SRC_EXT3 = 3'd7
    } src_e;

    // field positions inside one nibble of the control register
    localparam int F_TYPE = 0;
    localparam int F_FLAG = 1;
    localparam int F_EN   = 2;
    localparam int F_PRI  = 3;

    typedef struct packed {
        logic [7:0] xctl;
        logic [1:0] ext01_flag;
        logic       svc_hi;
        logic       svc_lo;
    } intc_state_t;
endpackage

// File: rtl/intc_pin_sync.sv
module intc_pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] fall
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;
    logic [WIDTH-1:0]             prev_d, prev_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
        prev_d = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= '1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign dout = chain_q[STAGES-1];
    assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NREQ = 8,
    localparam int IW  = $clog2(NREQ)
) (
    input  logic [NREQ-1:0] req,
    input  logic [NREQ-1:0] hi,
    input  logic            allow_hi,
    input  logic            allow_lo,
    output logic            valid,
    output logic [IW-1:0]   idx,
    output logic            is_hi
);
    logic [NREQ-1:0] hi_m, lo_m, pick;

    always_comb begin
        hi_m  = req & hi & {NREQ{allow_hi}};
        lo_m  = req & ~hi & {NREQ{allow_lo}};
        is_hi = |hi_m;
        pick  = is_hi ? hi_m : lo_m;
        valid = |pick;
        idx   = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (pick[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
    import intc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VEC_BASE    = 3,
    parameter int VEC_STRIDE  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] pin_n,
    input  logic [1:0] edge_sel01,
    input  logic [5:0] std_en,
    input  logic [5:0] std_hi,
    input  logic [2:0] tmr_req,
    input  logic       ser_req,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       bit_wr,
    input  logic [2:0] bit_sel,
    input  logic       bit_val,
    output logic [7:0] reg_rdata,
    input  logic       ack,
    input  logic       reti,
    output logic       irq,
    output logic [7:0] vec,
    output logic       svc_hi,
    output logic       svc_lo
);
    localparam int NPIN = 4;

    intc_state_t st_d, st_q;

    logic [NPIN-1:0] pin_s, pin_fall;
    logic [NSRC-1:0] req_w, hi_w;
    logic            win_valid, win_hi;
    logic [IDXW-1:0] win_idx;
    logic            take;
    logic [1:0]      x_type, x_flag, x_en, x_pri, x_set, x_clr;
    logic [1:0]      s_set, s_clr;

    intc_pin_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_n),
        .dout (pin_s),
        .fall (pin_fall)
    );

    // per-nibble field view of the added pins
    always_comb begin
        for (int p = 0; p < 2; p++) begin
            x_type[p] = st_q.xctl[4*p + F_TYPE];
            x_flag[p] = st_q.xctl[4*p + F_FLAG];
            x_en[p]   = st_q.xctl[4*p + F_EN];
            x_pri[p]  = st_q.xctl[4*p + F_PRI];
        end
    end

    always_comb begin
        req_w[SRC_EXT0] = std_en[0] & (edge_sel01[0] ? st_q.ext01_flag[0] : ~pin_s[0]);
        req_w[SRC_TMR0] = std_en[1] & tmr_req[0];
        req_w[SRC_EXT1] = std_en[2] & (edge_sel01[1] ? st_q.ext01_flag[1] : ~pin_s[1]);
        req_w[SRC_TMR1] = std_en[3] & tmr_req[1];
        req_w[SRC_SER]  = std_en[4] & ser_req;
        req_w[SRC_TMR2] = std_en[5] & tmr_req[2];
        req_w[SRC_EXT2] = x_en[0] & (x_type[0] ? x_flag[0] : ~pin_s[2]);
        req_w[SRC_EXT3] = x_en[1] & (x_type[1] ? x_flag[1] : ~pin_s[3]);
        hi_w = {x_pri, std_hi};
    end

    intc_arbiter #(.NREQ(NSRC)) u_arb (
        .req     (req_w),
        .hi      (hi_w),
        .allow_hi(~st_q.svc_hi),
        .allow_lo(~st_q.svc_hi & ~st_q.svc_lo),
        .valid   (win_valid),
        .idx     (win_idx),
        .is_hi   (win_hi)
    );

    assign take = ack & win_valid;

    always_comb begin
        st_d = st_q;

        // software access: byte first, then single bit
        if (reg_wr) st_d.xctl = reg_wdata;
        if (bit_wr) st_d.xctl[bit_sel] = bit_val;

        // hardware set on falling edge, clear on service (set wins)
        s_set = edge_sel01 & pin_fall[1:0];
        x_set = x_type & pin_fall[3:2];
        s_clr[0] = take & (win_idx == SRC_EXT0) & edge_sel01[0];
        s_clr[1] = take & (win_idx == SRC_EXT1) & edge_sel01[1];
        x_clr[0] = take & (win_idx == SRC_EXT2) & x_type[0];
        x_clr[1] = take & (win_idx == SRC_EXT3) & x_type[1];

        st_d.ext01_flag = (st_q.ext01_flag & ~s_clr) | s_set;
        for (int p = 0; p < 2; p++) begin
            st_d.xctl[4*p + F_FLAG] = (st_d.xctl[4*p + F_FLAG] & ~x_clr[p]) | x_set[p];
        end

        // service levels: return first, then entry
        if (reti) begin
            if (st_q.svc_hi) st_d.svc_hi = 1'b0;
            else             st_d.svc_lo = 1'b0;
        end
        if (take) begin
            if (win_hi) st_d.svc_hi = 1'b1;
            else        st_d.svc_lo = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.xctl;
    assign irq       = win_valid;
    assign vec       = 8'(VEC_BASE + int'(win_idx) * VEC_STRIDE);
    assign svc_hi    = st_q.svc_hi;
    assign svc_lo    = st_q.svc_lo;

    // winner is really requesting
    assert_winner_requests_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> req_w[win_idx]);

    // a low winner means no high request was pending
    assert_high_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !win_hi) |-> ((req_w & hi_w) == '0));

    assert_silent_in_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_hi |-> !irq);

    assert_low_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_lo && irq) |-> win_hi);

    assert_ack_clears_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && win_idx == SRC_EXT2 && x_type[0] && !pin_fall[2] && !reg_wr && !bit_wr)
        |=> !reg_rdata[F_FLAG]);

    assert_reti_ends_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !take && svc_hi) |=> !svc_hi);
endmodule

// File: tb/test_intc_two_level.sv
module test_intc_two_level;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_n = 4'hF;
    logic [1:0] edge_sel01 = '0;
    logic [5:0] std_en = '0;
    logic [5:0] std_hi = '0;
    logic [2:0] tmr_req = '0;
    logic       ser_req = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       bit_wr = 1'b0;
    logic [2:0] bit_sel = '0;
    logic       bit_val = 1'b0;
    logic [7:0] reg_rdata;
    logic       ack = 1'b0;
    logic       reti = 1'b0;
    logic       irq;
    logic [7:0] vec;
    logic       svc_hi, svc_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_two_level i_intc_two_level (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .edge_sel01(edge_sel01),
        .std_en(std_en), .std_hi(std_hi), .tmr_req(tmr_req), .ser_req(ser_req),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .bit_wr(bit_wr), .bit_sel(bit_sel),
        .bit_val(bit_val), .reg_rdata(reg_rdata), .ack(ack), .reti(reti),
        .irq(irq), .vec(vec), .svc_hi(svc_hi), .svc_lo(svc_lo)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic wr_bit(input int pos, input logic v);
        bit_wr = 1'b1; bit_sel = 3'(pos); bit_val = v;
        tick(1);
        bit_wr = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(1); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; tick(1); reti = 1'b0;
    endtask

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;

        @(negedge clk);
        tick(2);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 reg", reg_rdata, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 svc", {svc_hi, svc_lo}, 0);

        // R2 byte and bit access
        wr_byte(8'hA5);
        chk("R2 byte", reg_rdata, 8'hA5);
        wr_bit(0, 1'b0);
        chk("R2 bit0", reg_rdata, 8'hA4);
        wr_bit(6, 1'b1);
        chk("R2 bit6", reg_rdata, 8'hE4);
        // R4 stored flag of pin 3 in level mode with pin high: no request
        tick(1);
        chk("R4 flag ignored", irq, 0);
        wr_byte(8'h00);

        // R11 everything requesting, nothing enabled
        pin_n = 4'h0; tmr_req = 3'h7; ser_req = 1'b1;
        tick(3);
        chk("R11 disabled", irq, 0);
        pin_n = 4'hF; tmr_req = '0; ser_req = 1'b0;
        tick(3);

        // R5 R6 R7 sweep over all request patterns
        std_en = 6'h3F; edge_sel01 = 2'b00;
        for (int p = 0; p < 4; p++) begin
            logic [7:0] hp;
            hp = pats[p];
            std_hi = hp[5:0];
            wr_byte({hp[7], 1'b1, 2'b00, hp[6], 1'b1, 2'b00});
            for (int m = 0; m < 256; m++) begin
                logic [7:0] mm, hm;
                int e;
                mm = 8'(m);
                pin_n   = {~mm[7], ~mm[6], ~mm[2], ~mm[0]};
                tmr_req = {mm[5], mm[3], mm[1]};
                ser_req = mm[4];
                tick(3);
                hm = mm & hp;
                e = -1;
                for (int i = 7; i >= 0; i--) if (hm[i]) e = i;
                if (e < 0) for (int i = 7; i >= 0; i--) if (mm[i]) e = i;
                chk("R6 R7 irq", irq, (e >= 0) ? 1 : 0);
                if (e >= 0) chk("R5 R6 R7 vec", vec, 3 + 8 * e);
            end
        end
        pin_n = 4'hF; tmr_req = '0; ser_req = 1'b0; std_hi = '0;
        wr_byte(8'h00);
        tick(3);

        // R3 R8 edge mode on pin 2
        wr_byte(8'h05);
        pin_n[2] = 1'b0;
        tick(3);
        chk("R3 flag set", reg_rdata, 8'h07);
        chk("R3 irq", irq, 1);
        chk("R5 vec ext2", vec, 8'h33);
        pulse_ack();
        chk("R8 edge flag cleared", reg_rdata, 8'h05);
        chk("R8 low level entered", {svc_hi, svc_lo}, 1);
        chk("R8 no request after clear", irq, 0);
        pulse_reti();
        chk("R10 low ended", svc_lo, 0);
        chk("R3 held low no new edge", irq, 0);
        pin_n[2] = 1'b1; tick(3);
        pin_n[2] = 1'b0; tick(3);
        chk("R3 second edge", reg_rdata, 8'h07);
        wr_byte(8'h00);
        pin_n[2] = 1'b1;
        tick(3);

        // R4 R8 level mode on pin 3
        wr_byte(8'h40);
        pin_n[3] = 1'b0;
        tick(3);
        chk("R4 irq", irq, 1);
        chk("R5 vec ext3", vec, 8'h3B);
        chk("R4 no flag", reg_rdata, 8'h40);
        pulse_ack();
        chk("R8 level service", svc_lo, 1);
        chk("R9 low blocked", irq, 0);
        pulse_reti();
        chk("R8 level persists", irq, 1);
        pin_n[3] = 1'b1;
        tick(3);
        chk("R4 released", irq, 0);
        wr_byte(8'h00);

        // R9 R10 nesting
        std_en = 6'h3F; std_hi = 6'b000010;
        ser_req = 1'b1; tick(1);
        chk("R9 serial vec", vec, 8'h23);
        pulse_ack();
        chk("R8 enter low", {svc_hi, svc_lo}, 1);
        chk("R9 low blocks low", irq, 0);
        tmr_req[0] = 1'b1; tick(1);
        chk("R9 high preempts", irq, 1);
        chk("R9 high vec", vec, 8'h0B);
        pulse_ack();
        chk("R8 enter high", {svc_hi, svc_lo}, 3);
        chk("R9 silent in high", irq, 0);
        pulse_reti();
        chk("R10 high ended first", {svc_hi, svc_lo}, 1);
        chk("R9 high again", irq, 1);
        tmr_req[0] = 1'b0; tick(1);
        chk("R9 low still blocked", irq, 0);
        pulse_reti();
        chk("R10 low ended", {svc_hi, svc_lo}, 0);
        chk("R6 serial returns", vec, 8'h23);
        chk("R6 serial irq", irq, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule